// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the controller-side transmitter of a serial audio link. It runs on the rising edges of the link bit clock and produces two registered outputs. The first is a frame strobe, whose low-to-high transition marks the start of each frame. The second is a serial data line that carries a 256-bit frame, most significant bit first. Each frame opens with a 16-bit tag slot, followed by twelve 20-bit data slots. The tag tells the receiver which data slots carry valid content. Every bit position that holds no valid content is sent as zero.

The surrounding logic presents twelve 20-bit data words, twelve valid flags, a sample-width setting and a mono flag. The block captures all of them on the bit-clock edge that raises the strobe. That captured set is the content of the frame that follows, and input changes during the rest of the frame have no effect until the next capture. Samples narrower than 20 bits are sent MSB-justified, and their trailing positions are cleared. In mono mode the right-channel slot repeats the left-channel slot, both its data and its valid flag.

Top module: `ac_link_tx`

## Requirements
- R1: A frame lasts 256 bit-clock periods. `ac_sync` is high for the first 16 periods of each frame and low for the other 240.
- R2: `ac_sdout` lags the frame by one period. During the period in which `ac_sync` rises, it carries the final bit of the previous frame (0 for the first frame after reset). Stream bit k (k = 0..255) appears in frame period k+1, and bit 255 appears in period 0 of the next frame.
- R3: Stream bit 0 (tag bit 15) is 1 if and only if at least one data slot is valid after the mono substitution.
- R4: Stream bits 1..12 (tag bits 14..3) are the valid flags of data slots 1..12 in that order. Slot n is flagged by `slot_valid[n-1]`.
- R5: Stream bits 13..15 (tag bits 2..0) are always 0.
- R6: Data slot n occupies stream bits 16+20(n-1) through 35+20(n-1). Its word is `slot_data[20(n-1) +: 20]`, sent from bit 19 down to bit 0.
- R7: Every bit of a data slot whose valid flag is 0 is sent as 0, whatever its data word holds.
- R8: With `samp_width` = w in 1..20, only the first w bits of each valid slot (the w most significant bits of its word) are sent. The remaining 20-w bit positions are 0. A value of 0 or above 20 selects the full 20 bits.
- R9: When `mono_en` is 1, slot 4 carries the data word and valid flag of slot 3. The slot 4 inputs have no effect in this mode.
- R10: All inputs are captured on the bit-clock edge that raises `ac_sync`. Input changes at any other time do not alter the frame being sent.
- R11: While `rst` is high on a clock edge, `ac_sync` and `ac_sdout` are driven low. The first edge with `rst` low starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| slot_data | input | 240 | Twelve 20-bit slot words; slot n at bits [20(n-1) +: 20] |
| slot_valid | input | 12 | Valid flag per data slot; bit n-1 for slot n |
| samp_width | input | 5 | Number of leading sample bits kept per slot (0 or >20 means 20) |
| mono_en | input | 1 | Repeat slot 3 content in slot 4 |
| ac_sync | output | 1 | Frame strobe, high for the 16 tag periods |
| ac_sdout | output | 1 | Serial frame data, MSB first |

## Verification
A fault in the frame position counter shows up on `ac_sync` as a strobe that is too long or too short, or as a wrong frame period. The fault becomes visible at the first strobe edge after it, within at most 256 cycles. A fault in the shift register or the packing logic appears on `ac_sdout` in the very bit period that holds the affected position. Which requirement fails depends on that position: a tag flag, a cleared trailing bit, a zero-filled invalid slot or the duplicated mono slot. A capture fault, where inputs leak into a frame after its start, shows up only when inputs change in mid-frame. The bench therefore disturbs the inputs during the tag slot and during the data slots, and it compares every bit of the frame.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;
  localparam int AC_NUM_SLOTS = 12;
  localparam int AC_SLOT_W    = 20;
  localparam int AC_TAG_W     = 16;
  localparam int AC_WIDTH_W   = 5;
  // zero-based slot indices of the left/right pair used for mono
  localparam int AC_LEFT_IDX  = 2;
  localparam int AC_RIGHT_IDX = 3;

  typedef enum logic {
    PH_BODY = 1'b0,
    PH_TAG  = 1'b1
  } frame_phase_e;
endpackage

// File: rtl/ac_frame_timer.sv
module ac_frame_timer
  import ac_link_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int TAG_W     = 16
) (
  input  logic clk,
  input  logic rst,
  output logic load_o,
  output logic sync_o
);
  localparam int CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0] pos_q;
  frame_phase_e     phase_q;

  // position 0 is the edge that raises the strobe and captures the frame
  assign load_o = (pos_q == '0);
  assign sync_o = (phase_q == PH_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      phase_q <= PH_BODY;
    end else begin
      pos_q   <= (pos_q == CNT_W'(FRAME_LEN - 1)) ? '0 : pos_q + 1'b1;
      phase_q <= (pos_q < CNT_W'(TAG_W)) ? PH_TAG : PH_BODY;
    end
  end
endmodule

// File: rtl/ac_slot_packer.sv
module ac_slot_packer
  import ac_link_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 20,
  parameter int TAG_W     = 16,
  parameter int WIDTH_W   = 5,
  parameter int LEFT_IDX  = 2,
  parameter int RIGHT_IDX = 3
) (
  input  logic [NUM_SLOTS*SLOT_W-1:0]       slot_data,
  input  logic [NUM_SLOTS-1:0]              slot_valid,
  input  logic [WIDTH_W-1:0]                samp_width,
  input  logic                              mono_en,
  output logic [TAG_W+NUM_SLOTS*SLOT_W-1:0] frame_vec
);
  localparam int PAY_W = NUM_SLOTS * SLOT_W;
  localparam int PAD_W = TAG_W - 1 - NUM_SLOTS;

  logic [NUM_SLOTS-1:0] vld_eff;
  logic [NUM_SLOTS-1:0] flags_rev;
  logic [PAY_W-1:0]     payload;
  logic [SLOT_W-1:0]    keep_mask;
  logic [TAG_W-1:0]     tag;
  int                   w_eff;

  // width 0 or beyond the slot selects the full slot
  always_comb begin
    if (samp_width == '0 || int'(samp_width) > SLOT_W) w_eff = SLOT_W;
    else                                              w_eff = int'(samp_width);
    for (int b = 0; b < SLOT_W; b++) begin
      keep_mask[b] = (b >= SLOT_W - w_eff);
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [SLOT_W-1:0] raw;
    logic              dup;
    assign dup        = mono_en && (i == RIGHT_IDX);
    assign raw        = dup ? slot_data[LEFT_IDX*SLOT_W +: SLOT_W]
                            : slot_data[i*SLOT_W +: SLOT_W];
    assign vld_eff[i] = dup ? slot_valid[LEFT_IDX] : slot_valid[i];
    // slot 1 leads the payload, so it sits at the top
    assign payload[(NUM_SLOTS-1-i)*SLOT_W +: SLOT_W] =
      vld_eff[i] ? (raw & keep_mask) : '0;
    assign flags_rev[NUM_SLOTS-1-i] = vld_eff[i];
  end

  assign tag       = {|vld_eff, flags_rev, {PAD_W{1'b0}}};
  assign frame_vec = {tag, payload};
endmodule

// File: rtl/ac_frame_shifter.sv
module ac_frame_shifter #(
  parameter int FRAME_LEN = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [FRAME_LEN-1:0] frame_vec,
  output logic                 sdout_o
);
  logic [FRAME_LEN-1:0] shreg_q;

  // the output flop takes the top bit before the load overwrites it,
  // which gives the one-period lag behind the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      sdout_o <= 1'b0;
    end else begin
      sdout_o <= shreg_q[FRAME_LEN-1];
      shreg_q <= load ? frame_vec : {shreg_q[FRAME_LEN-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/ac_link_tx.sv
module ac_link_tx
  import ac_link_pkg::*;
#(
  parameter int NUM_SLOTS = AC_NUM_SLOTS,
  parameter int SLOT_W    = AC_SLOT_W,
  parameter int TAG_W     = AC_TAG_W,
  parameter int WIDTH_W   = AC_WIDTH_W,
  parameter int LEFT_IDX  = AC_LEFT_IDX,
  parameter int RIGHT_IDX = AC_RIGHT_IDX
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_data,
  input  logic [NUM_SLOTS-1:0]        slot_valid,
  input  logic [WIDTH_W-1:0]          samp_width,
  input  logic                        mono_en,
  output logic                        ac_sync,
  output logic                        ac_sdout
);
  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;

  logic                 load;
  logic [FRAME_LEN-1:0] frame_vec;

  ac_frame_timer #(.FRAME_LEN(FRAME_LEN), .TAG_W(TAG_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_o (load),
    .sync_o (ac_sync)
  );

  ac_slot_packer #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W),
    .WIDTH_W(WIDTH_W), .LEFT_IDX(LEFT_IDX), .RIGHT_IDX(RIGHT_IDX)
  ) u_packer (
    .slot_data  (slot_data),
    .slot_valid (slot_valid),
    .samp_width (samp_width),
    .mono_en    (mono_en),
    .frame_vec  (frame_vec)
  );

  ac_frame_shifter #(.FRAME_LEN(FRAME_LEN)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .frame_vec (frame_vec),
    .sdout_o   (ac_sdout)
  );
endmodule

// File: rtl/ac_link_tx_chk.sv
module ac_link_tx_chk #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 20,
  parameter int TAG_W     = 16,
  parameter int LEFT_IDX  = 2,
  parameter int RIGHT_IDX = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_SLOTS-1:0] slot_valid,
  input logic                 mono_en,
  input logic                 ac_sync,
  input logic                 ac_sdout
);
  localparam int LOW_LEN = NUM_SLOTS * SLOT_W;

  logic [15:0]          hi_run;
  logic [15:0]          lo_run;
  logic                 seen_fall;
  logic [NUM_SLOTS-1:0] v_eff;
  logic                 any_vld;

  always_comb begin
    v_eff = slot_valid;
    if (mono_en) v_eff[RIGHT_IDX] = slot_valid[LEFT_IDX];
    any_vld = |v_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run    <= '0;
      lo_run    <= '0;
      seen_fall <= 1'b0;
    end else begin
      hi_run    <= ac_sync ? hi_run + 16'd1 : 16'd0;
      lo_run    <= ac_sync ? 16'd0 : lo_run + 16'd1;
      if (!ac_sync && hi_run != 16'd0) seen_fall <= 1'b1;
    end
  end

  // R1
  sync_high_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ac_sync) |-> hi_run == 16'(TAG_W));

  // R1
  sync_low_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ac_sync) && seen_fall) |-> lo_run == 16'(LOW_LEN));

  // R1
  sync_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hi_run <= 16'(TAG_W));

  // R5
  tag_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ac_sync) |-> !$past(ac_sdout));

  // R3
  frame_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ac_sync) |=> ac_sdout == $past(any_vld, 2));
endmodule

bind ac_link_tx ac_link_tx_chk #(
  .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W),
  .LEFT_IDX(LEFT_IDX), .RIGHT_IDX(RIGHT_IDX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_valid (slot_valid),
  .mono_en    (mono_en),
  .ac_sync    (ac_sync),
  .ac_sdout   (ac_sdout)
);

// File: tb/tb_ac_link_tx.sv
module tb_ac_link_tx;
  localparam int NS = 12;
  localparam int SW = 20;
  localparam int TW = 16;
  localparam int WW = 5;
  localparam int FL = TW + NS * SW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NS*SW-1:0] slot_data = '0;
  logic [NS-1:0]    slot_valid = '0;
  logic [WW-1:0]    samp_width = '0;
  logic             mono_en = 1'b0;
  logic             ac_sync;
  logic             ac_sdout;

  int   n_checks = 0;
  int   n_fail = 0;
  int   frame_no = 0;
  bit   done = 1'b0;
  logic prev_last = 1'b0;

  always #10 clk = ~clk;

  ac_link_tx dut (
    .clk(clk), .rst(rst), .slot_data(slot_data), .slot_valid(slot_valid),
    .samp_width(samp_width), .mono_en(mono_en),
    .ac_sync(ac_sync), .ac_sdout(ac_sdout)
  );

  function automatic int eff_width(input logic [WW-1:0] w);
    return (w == 0 || int'(w) > SW) ? SW : int'(w);
  endfunction

  function automatic logic [NS-1:0] eff_valid(input logic [NS-1:0] v, input logic m);
    logic [NS-1:0] r = v;
    if (m) r[3] = v[2];
    return r;
  endfunction

  // stream bit k is placed at index FL-1-k
  function automatic logic [FL-1:0] model(input logic [NS*SW-1:0] d, input logic [NS-1:0] v,
                                          input logic [WW-1:0] w, input logic m);
    logic [FL-1:0] f = '0;
    logic [NS-1:0] ve = eff_valid(v, m);
    int we = eff_width(w);
    f[FL-1] = |ve;
    for (int s = 0; s < NS; s++) f[FL-2-s] = ve[s];
    for (int k = TW; k < FL; k++) begin
      int s = (k - TW) / SW;
      int b = (k - TW) % SW;
      int src = (m && s == 3) ? 2 : s;
      if (ve[s] && b < we) f[FL-1-k] = d[src*SW + (SW-1-b)];
    end
    return f;
  endfunction

  function automatic string region(input int k, input logic [NS-1:0] v,
                                   input logic [WW-1:0] w, input logic m);
    logic [NS-1:0] ve = eff_valid(v, m);
    int s, b;
    if (k == 0) return "R3";
    if (k <= NS) return "R4";
    if (k < TW) return "R5";
    s = (k - TW) / SW;
    b = (k - TW) % SW;
    if (!ve[s]) return "R7";
    if (b >= eff_width(w)) return "R8";
    if (m && s == 3) return "R9";
    return "R6";
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s frame %0d %s: got %0b expected %0b", req, frame_no, what, got, exp);
    end
  endtask

  function automatic logic [NS*SW-1:0] rnd_data();
    logic [NS*SW-1:0] r;
    for (int s = 0; s < NS; s++) r[s*SW +: SW] = SW'($urandom);
    return r;
  endfunction

  task automatic run_frame(input logic [NS*SW-1:0] d, input logic [NS-1:0] v,
                           input logic [WW-1:0] w, input logic m, input bit scr);
    logic [FL-1:0] e;
    string rq;
    slot_data = d; slot_valid = v; samp_width = w; mono_en = m;
    e = model(d, v, w, m);
    for (int p = 0; p < FL; p++) begin
      @(posedge clk);
      @(negedge clk);
      check(ac_sync, p < TW, (frame_no == 0 && p == 0) ? "R1 R11" : "R1",
            $sformatf("sync pos %0d", p));
      if (p == 0) rq = "R2";
      else rq = region(p - 1, v, w, m);
      if (scr) rq = {rq, " R10"};
      check(ac_sdout, (p == 0) ? prev_last : e[FL-p], rq, $sformatf("sdout pos %0d", p));
      if (scr && (p == 5 || p == 100 || p == 200)) begin
        slot_data = rnd_data(); slot_valid = NS'($urandom);
        samp_width = WW'($urandom); mono_en = 1'($urandom);
      end
    end
    prev_last = e[0];
    frame_no++;
  endtask

  initial begin
    logic [NS*SW-1:0] d;
    void'($urandom(32'd20240611));
    // R11: outputs held low during reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(ac_sync, 1'b0, "R11", "sync in reset");
      check(ac_sdout, 1'b0, "R11", "sdout in reset");
    end
    rst = 1'b0;
    d = rnd_data();
    run_frame({NS*SW{1'b1}}, '0, 5'd20, 1'b0, 1'b0);      // R3/R7: nothing valid
    run_frame(d, '1, 5'd20, 1'b0, 1'b0);                  // R6 full width
    run_frame(rnd_data(), '1, 5'd8, 1'b0, 1'b0);          // R8 eight bits
    run_frame(rnd_data(), '1, 5'd0, 1'b0, 1'b0);          // R8 zero means full
    run_frame(rnd_data(), '1, 5'd25, 1'b0, 1'b0);         // R8 over range
    run_frame({NS*SW{1'b1}}, '1, 5'd1, 1'b0, 1'b0);       // R8 single bit
    run_frame(rnd_data(), '1, 5'd20, 1'b1, 1'b0);         // R9 mono
    run_frame({NS*SW{1'b1}}, 12'b0000_0000_1000, 5'd20, 1'b1, 1'b0); // R9: slot 4 alone ignored
    run_frame({NS*SW{1'b1}}, 12'h800, 5'd16, 1'b0, 1'b0); // R4 last slot only
    run_frame(rnd_data(), 12'h5A3, 5'd12, 1'b0, 1'b1);    // R10 disturbed inputs
    for (int i = 0; i < 12; i++)
      run_frame(rnd_data(), NS'($urandom), WW'($urandom), 1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule